// File: doc/BRIEF.md
# Interrupt Request Priority Core

This block is the request-handling heart of an eight-line programmable interrupt controller. It captures requests from eight device lines into a request register, either by level or by rising edge. It hides masked lines and picks the most urgent pending line. It raises `int_out` only when that line outranks everything already in service.

The processor acknowledges in two strobes on `inta`. The first strobe moves the winning request into the in-service register. The second strobe returns an 8-bit vector on `vec_out`, qualified by `vec_valid`. Service ends in one of three ways: a non-specific end-of-interrupt, a specific end-of-interrupt naming a level, or automatically when auto-EOI is set. The trigger mode, vector base, auto-EOI and rotating priority are static configuration inputs. The command-word decoder and cascading live outside this block.

Top module: `irq_prio_core`

## Requirements
- R1: With rotation off, line 0 has the highest priority and line 7 the lowest.
- R2: In level mode (`cfg_level`=1) a request bit follows its line: it is set one clock after the line is high and cleared one clock after the line is low.
- R3: In edge mode (`cfg_level`=0) a request bit is set only by a low-to-high transition of its line. A line held high after its request was acknowledged raises no new request.
- R4: A line whose `mask` bit is 1 produces no `int_out`.
- R5: `int_out` is high exactly when the best unmasked pending line has strictly higher priority than the best in-service line (or nothing is in service).
- R6: `inta` is a one-clock strobe. The first strobe clears the winning request bit and sets its in-service bit. The second strobe makes `vec_valid` high for the following clock with the vector on `vec_out`.
- R7: The vector is `{cfg_vec_base, line}`: bits 7:3 carry the base and bits 2:0 carry the line number.
- R8: An EOI with `eoi_specific`=0 clears the highest-priority in-service bit.
- R9: An EOI with `eoi_specific`=1 clears the in-service bit numbered by `eoi_level`.
- R10: With `cfg_auto_eoi`=1 the in-service bit is cleared at the second strobe, so no EOI is needed.
- R11: With `cfg_rotate`=1, each serviced line becomes the lowest priority when its service ends, and priority continues upward from the next line number, wrapping from 7 to 0.
- R12: If no line qualifies for `int_out` at the first strobe, the vector returned carries line number 7 and no in-service bit is set.
- R13: After reset `int_out` and `vec_valid` are low and no request or in-service bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_lines | input | 8 | Device request lines |
| mask | input | 8 | Per-line mask, 1 = masked |
| cfg_level | input | 1 | 1 = level capture, 0 = rising-edge capture |
| cfg_vec_base | input | 5 | Vector base, placed in vector bits 7:3 |
| cfg_auto_eoi | input | 1 | End service automatically at the second strobe |
| cfg_rotate | input | 1 | Rotating priority enable |
| inta | input | 1 | Acknowledge strobe, one clock per pulse |
| eoi_valid | input | 1 | End-of-interrupt command strobe |
| eoi_specific | input | 1 | 1 = clear the level in `eoi_level` |
| eoi_level | input | 3 | Line number for a specific EOI |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, one clock |
| vec_out | output | 8 | Interrupt vector |

## Verification
The in-service register and the rotation pointer cannot be read directly. A corrupted bit in either one shows up only through `int_out` and the next vector. A stale in-service bit holds `int_out` low for a lower line that should be raised, and the bench detects this on the clock after the line rises. A wrong rotation pointer changes which line wins the next acknowledge, so the scoreboard catches it at the second strobe of that sequence. A request bit left set in edge mode, or not cleared in level mode, shows as an `int_out` level that differs from the expected one on the sample taken one clock after the line changes.

// File: rtl/irq_pkg.sv
// Shared sizes for the interrupt request priority core.
// Assumes the line count is a power of two so that priority arithmetic wraps.
package irq_pkg;
    localparam int LINES_DEF = 8;
    localparam int VEC_W_DEF = 8;
endpackage

// File: rtl/irq_req_capture.sv
// Request capture: turns device lines into request bits, by level or by
// rising edge, and drops the bits that the acknowledge logic consumes.
// Assumes lines are already synchronous to clk.
module irq_req_capture #(
    parameter int N = irq_pkg::LINES_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic         level_mode,
    input  logic [N-1:0] take,
    output logic [N-1:0] irr
);
    logic [N-1:0] prev_q;

    // Track previous line levels and update the request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr    <= '0;
        end else begin
            prev_q <= lines;
            if (level_mode)
                irr <= lines & ~take;
            else
                irr <= (irr | (lines & ~prev_q)) & ~take;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Priority picker: finds the set bit that ranks best when priority starts
// just above the line named by low_line and wraps around.
// Assumes N is a power of two; rank 0 is the best.
module irq_prio_pick #(
    parameter int N     = irq_pkg::LINES_DEF,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] low_line,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] rank
);
    // Scan from the worst rank to the best so the best hit is kept last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        rank  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            logic [IDX_W-1:0] cand;
            cand = low_line + IDX_W'(1) + IDX_W'(k);
            if (req[cand]) begin
                found = 1'b1;
                idx   = cand;
                rank  = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/irq_prio_core.sv
// Interrupt request priority core: request capture, masking, priority
// resolution against the in-service set, two-strobe acknowledge, vector
// output and end-of-interrupt handling with optional rotation.
// Assumes configuration inputs are stable across an acknowledge sequence.
module irq_prio_core #(
    parameter int N      = irq_pkg::LINES_DEF,
    parameter int VEC_W  = irq_pkg::VEC_W_DEF,
    parameter int IDX_W  = $clog2(N),
    parameter int BASE_W = VEC_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req_lines,
    input  logic [N-1:0]      mask,
    input  logic              cfg_level,
    input  logic [BASE_W-1:0] cfg_vec_base,
    input  logic              cfg_auto_eoi,
    input  logic              cfg_rotate,
    input  logic              inta,
    input  logic              eoi_valid,
    input  logic              eoi_specific,
    input  logic [IDX_W-1:0]  eoi_level,
    output logic              int_out,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_out
);
    logic [N-1:0]     irr, isr, pending;
    logic [N-1:0]     take, isr_set, isr_clr;
    logic [IDX_W-1:0] rot_low, eff_low, rot_val;
    logic             rot_upd;
    logic             p_found, s_found;
    logic [IDX_W-1:0] p_idx, p_rank, s_idx, s_rank;
    logic             ack_phase, held_spur;
    logic [IDX_W-1:0] held_idx;
    logic             first_ack, second_ack;

    irq_req_capture #(.N(N)) u_cap (
        .clk(clk), .rst_n(rst_n), .lines(req_lines),
        .level_mode(cfg_level), .take(take), .irr(irr)
    );

    assign pending = irr & ~mask;
    assign eff_low = cfg_rotate ? rot_low : {IDX_W{1'b1}};

    irq_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick_req (
        .req(pending), .low_line(eff_low),
        .found(p_found), .idx(p_idx), .rank(p_rank)
    );

    irq_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick_svc (
        .req(isr), .low_line(eff_low),
        .found(s_found), .idx(s_idx), .rank(s_rank)
    );

    // Raise the request only when the pending winner outranks service.
    assign int_out    = p_found && (!s_found || (p_rank < s_rank));
    assign first_ack  = inta && !ack_phase;
    assign second_ack = inta && ack_phase;

    // Decide which request and in-service bits move this clock.
    always_comb begin
        take    = '0;
        isr_set = '0;
        isr_clr = '0;
        rot_upd = 1'b0;
        rot_val = '0;
        if (first_ack && int_out) begin
            take[p_idx]    = 1'b1;
            isr_set[p_idx] = 1'b1;
        end
        if (second_ack && cfg_auto_eoi && !held_spur) begin
            isr_clr[held_idx] = 1'b1;
            rot_upd = 1'b1;
            rot_val = held_idx;
        end
        if (eoi_valid) begin
            if (eoi_specific) begin
                isr_clr[eoi_level] = 1'b1;
                rot_upd = 1'b1;
                rot_val = eoi_level;
            end else if (s_found) begin
                isr_clr[s_idx] = 1'b1;
                rot_upd = 1'b1;
                rot_val = s_idx;
            end
        end
    end

    // In-service register, rotation pointer, acknowledge phase and vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr       <= '0;
            rot_low   <= {IDX_W{1'b1}};
            ack_phase <= 1'b0;
            held_idx  <= '0;
            held_spur <= 1'b0;
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            isr <= (isr & ~isr_clr) | isr_set;
            if (rot_upd && cfg_rotate)
                rot_low <= rot_val;
            if (inta)
                ack_phase <= !ack_phase;
            if (first_ack) begin
                held_idx  <= int_out ? p_idx : {IDX_W{1'b1}};
                held_spur <= !int_out;
            end
            vec_valid <= second_ack;
            if (second_ack)
                vec_out <= {cfg_vec_base, held_idx};
        end
    end
endmodule

// File: rtl/irq_prio_core_chk.sv
// Property checker for the interrupt request priority core, bound to it.
// Assumes configuration is held stable around acknowledge sequences.
module irq_prio_core_chk #(
    parameter int N      = irq_pkg::LINES_DEF,
    parameter int VEC_W  = irq_pkg::VEC_W_DEF,
    parameter int IDX_W  = $clog2(N),
    parameter int BASE_W = VEC_W - IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      irr,
    input logic [N-1:0]      isr,
    input logic [N-1:0]      mask,
    input logic              inta,
    input logic              int_out,
    input logic              vec_valid,
    input logic [VEC_W-1:0]  vec_out,
    input logic [BASE_W-1:0] cfg_vec_base,
    input logic              cfg_auto_eoi
);
    // R4 / R5: a raised interrupt needs an unmasked request behind it.
    a_r4_int_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~mask) != '0));

    // R6: a vector appears only after an acknowledge strobe, for one clock.
    a_r6_vec_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(inta));
    a_r6_vec_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R6: one acknowledge adds at most one in-service bit.
    a_r6_isr_one_new: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr & ~$past(isr)) <= 1);

    // R7: vector upper bits carry the configured base.
    a_r7_vec_base: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_out[VEC_W-1:IDX_W] == cfg_vec_base));

    // R10: with auto-EOI the delivered line is no longer in service.
    a_r10_auto_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && cfg_auto_eoi) |-> !isr[vec_out[IDX_W-1:0]]);
endmodule

bind irq_prio_core irq_prio_core_chk #(
    .N(N), .VEC_W(VEC_W), .IDX_W(IDX_W), .BASE_W(BASE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irr(irr), .isr(isr), .mask(mask),
    .inta(inta), .int_out(int_out), .vec_valid(vec_valid),
    .vec_out(vec_out), .cfg_vec_base(cfg_vec_base),
    .cfg_auto_eoi(cfg_auto_eoi)
);

// File: tb/irq_prio_core_tb_top.sv
// Scoreboard bench: the driver pushes expected vectors, a monitor pops and
// compares them whenever vec_valid is seen; int_out is checked directly.
module irq_prio_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_lines = '0;
    logic [7:0] mask = '0;
    logic       cfg_level = 1'b1;
    logic [4:0] cfg_vec_base = 5'h04;
    logic       cfg_auto_eoi = 1'b0;
    logic       cfg_rotate = 1'b0;
    logic       inta = 1'b0;
    logic       eoi_valid = 1'b0;
    logic       eoi_specific = 1'b0;
    logic [2:0] eoi_level = '0;
    logic       int_out, vec_valid;
    logic [7:0] vec_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    irq_prio_core dut_i (
        .clk(clk), .rst_n(rst_n), .req_lines(req_lines), .mask(mask),
        .cfg_level(cfg_level), .cfg_vec_base(cfg_vec_base),
        .cfg_auto_eoi(cfg_auto_eoi), .cfg_rotate(cfg_rotate), .inta(inta),
        .eoi_valid(eoi_valid), .eoi_specific(eoi_specific),
        .eoi_level(eoi_level), .int_out(int_out), .vec_valid(vec_valid),
        .vec_out(vec_out)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_int(input logic e, input string req);
        @(negedge clk);
        n_chk++;
        if (int_out !== e) begin
            n_bad++;
            $display("FAIL %s int_out actual=%0b expected=%0b", req, int_out, e);
        end
    endtask

    // Two acknowledge strobes; the expected vector is queued before the second.
    task automatic ack(input logic [2:0] line, input string req);
        inta = 1'b1; tick(); inta = 1'b0; tick();
        exp_q.push_back({cfg_vec_base, line});
        tag_q.push_back(req);
        inta = 1'b1; tick(); inta = 1'b0; tick();
    endtask

    task automatic eoi(input logic spec, input logic [2:0] lvl);
        eoi_valid = 1'b1; eoi_specific = spec; eoi_level = lvl;
        tick();
        eoi_valid = 1'b0; eoi_specific = 1'b0;
    endtask

    task automatic drive(input logic [7:0] v);
        req_lines = v;
        tick();
    endtask

    task automatic finish_run();
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R6 vectors outstanding actual=%0d expected=0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: compare each delivered vector against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R6 unexpected vector actual=%02h expected=none", vec_out);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (vec_out !== e) begin
                    n_bad++;
                    $display("FAIL %s vector actual=%02h expected=%02h", t, vec_out, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R6 watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (5) tick();
        n_chk++;
        if (int_out !== 1'b0 || vec_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R13 reset actual=%0b%0b expected=00", int_out, vec_valid);
        end
        rst_n = 1'b1;
        tick();
        check_int(1'b0, "R13");

        // Level capture and basic vector.
        drive(8'h08); check_int(1'b1, "R2");
        ack(3'd3, "R7");
        check_int(1'b0, "R5");
        drive(8'h00); eoi(1'b0, 3'd0); check_int(1'b0, "R8");

        // Request withdrawn before acknowledge gives the spurious vector.
        drive(8'h04); drive(8'h00); check_int(1'b0, "R2");
        ack(3'd7, "R12");
        drive(8'h80); check_int(1'b1, "R12");
        ack(3'd7, "R12");
        drive(8'h00); eoi(1'b0, 3'd0); tick();

        // Masking.
        mask = 8'h40; drive(8'h40); check_int(1'b0, "R4");
        mask = 8'h00; tick(); check_int(1'b1, "R4");
        drive(8'h00); check_int(1'b0, "R2");

        // Fixed priority and nesting with non-specific EOI.
        drive(8'h42); check_int(1'b1, "R1");
        ack(3'd1, "R1");
        drive(8'h40); check_int(1'b0, "R5");
        drive(8'h41); check_int(1'b1, "R5");
        ack(3'd0, "R1");
        drive(8'h40);
        eoi(1'b0, 3'd0); check_int(1'b0, "R8");
        eoi(1'b0, 3'd0); check_int(1'b1, "R8");
        ack(3'd6, "R1");
        drive(8'h00); eoi(1'b0, 3'd0); check_int(1'b0, "R8");

        // Specific EOI.
        drive(8'h08); ack(3'd3, "R9");
        drive(8'h02); ack(3'd1, "R9");
        drive(8'h00);
        eoi(1'b1, 3'd3);
        drive(8'h20); check_int(1'b0, "R9");
        eoi(1'b0, 3'd0); check_int(1'b1, "R9");
        ack(3'd5, "R9");
        drive(8'h00); eoi(1'b0, 3'd0); tick();

        // Edge capture.
        cfg_level = 1'b0;
        drive(8'h10); check_int(1'b1, "R3");
        ack(3'd4, "R3");
        eoi(1'b0, 3'd0); check_int(1'b0, "R3");
        drive(8'h00); check_int(1'b0, "R3");
        drive(8'h10); check_int(1'b1, "R3");
        ack(3'd4, "R3");
        eoi(1'b0, 3'd0); drive(8'h00); tick();
        cfg_level = 1'b1;

        // Auto-EOI with another base.
        cfg_auto_eoi = 1'b1; cfg_vec_base = 5'h1F;
        drive(8'h10);
        ack(3'd4, "R10");
        check_int(1'b1, "R10");
        drive(8'h00); tick();
        cfg_auto_eoi = 1'b0; cfg_vec_base = 5'h04;
        check_int(1'b0, "R10");

        // Rotating priority.
        cfg_rotate = 1'b1;
        drive(8'h24); ack(3'd2, "R11");
        drive(8'h20); eoi(1'b0, 3'd0);
        drive(8'h22); ack(3'd5, "R11");
        drive(8'h02); eoi(1'b0, 3'd0);
        ack(3'd1, "R11");
        drive(8'h00); eoi(1'b0, 3'd0); check_int(1'b0, "R11");
        cfg_rotate = 1'b0;
        tick(); tick();
        finish_run();
    end
endmodule